// File: doc/BRIEF.md
# Transport Stream Sync Lock Monitor

This block watches a byte-wide transport stream, delivered with a per-byte valid strobe on its own stream clock, and decides whether the stream carries well-formed packets. It looks for sync bytes (0x47, or its bitwise inverse 0xB8) and measures how many valid bytes separate them. It locks to a packet length of 188 or 204 bytes on its own, without being told which one to expect. Entering lock takes more evidence than leaving it, so a stream is not declared good on a lucky match and not declared bad on one corrupt header.

A second, free-running reference clock drives the outward-facing status. A watchdog in that domain detects a stopped stream clock, drops the downstream port enable and raises an input-loss flag. The same domain stretches the sync-error lamp drive for a fixed hold time after lock is regained, so a short fault stays visible. It combines loss and sync error into one alarm, and it blanks the packet-length indicators while either fault is present. All status outputs come from the reference domain.

Top module: `ts_sync_monitor`

## Requirements
- R1: While locked, the block drops lock (sync_err rises) only when two consecutive expected sync positions hold a non-sync byte; one miss followed by a correct sync byte leaves lock intact and resets the miss tally.
- R2: Out of lock, sync_err clears when five consecutive sync-to-sync spacings all equal the same valid length, i.e. on the sixth sync byte; a sync byte at any other spacing restarts the count from zero with that byte as the new reference.
- R3: Byte values 0x47 and 0xB8 both count as sync bytes, freely mixed; every other value (for example 0x48) never counts.
- R4: The lock length is picked automatically: pkt188 is high when locked to 188-byte spacing, pkt204 when locked to 204-byte spacing, never both; spacings that alternate between 188 and 204 never produce lock.
- R5: While locked, sync-valued bytes that fall between expected sync positions are ignored and do not disturb lock.
- R6: err_led is high whenever sync_err is high, and stays high for exactly HOLD_CYCLES reference-clock cycles after sync_err falls (counted from the first reference cycle in which sync_err reads low), then goes low.
- R7: When the stream clock stops, input_loss rises within LOSS_CYCLES plus a few synchronizer cycles, and port_en falls; both return once the stream clock runs again. input_loss stays low while the stream clock runs.
- R8: alarm is high whenever input_loss or sync_err is high, and pkt188/pkt204 read low while either fault is present.
- R9: After reset: sync_err, err_led and alarm are high; pkt188, pkt204 and input_loss are low; port_en is high.
- R10: Cycles with ts_valid low are ignored: their byte is neither counted toward the spacing nor taken as a sync byte, even if it equals 0x47.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock for status, watchdog and lamp timer |
| clk_ts | input | 1 | Stream byte clock |
| rst | input | 1 | Synchronous active-high reset, applied in both clock domains |
| ts_byte | input | 8 | Stream byte |
| ts_valid | input | 1 | High when ts_byte carries a stream byte |
| sync_err | output | 1 | High while the stream is not locked |
| err_led | output | 1 | Sync-error lamp drive, stretched after recovery |
| pkt188 | output | 1 | Locked to 188-byte packets, blanked during faults |
| pkt204 | output | 1 | Locked to 204-byte packets, blanked during faults |
| input_loss | output | 1 | Stream clock has stopped |
| alarm | output | 1 | Input loss or sync error |
| port_en | output | 1 | Enable for the downstream data port, low during input loss |

## Verification
The bench attacks the hysteresis edges. It counts sync bytes up to the sixth and checks that lock has not arrived one early. It breaks a nearly finished run with a 150-byte spacing, which a tracker that did not restart its count would lock through too soon. It places a good header between two misses, which a design keeping a running miss total instead of a consecutive one would treat as a loss. Alternating 188/204 spacings, a 0x48 look-alike, inverted sync bytes, a stray 0x47 inside a locked payload and a 0x47 on a not-valid cycle catch trackers that match the wrong values or resynchronise on payload. The lamp hold is measured to the exact cycle, and the stream clock is stopped and restarted to show the port enable, the alarm and the indicator blanking following the loss flag both ways.

// File: rtl/ts_mon_pkg.sv
package ts_mon_pkg;

    typedef enum logic [1:0] {
        LEN_NONE = 2'd0,
        LEN_188  = 2'd1,
        LEN_204  = 2'd2
    } pkt_len_e;

    typedef enum logic {
        TRK_HUNT = 1'b0,
        TRK_LOCK = 1'b1
    } trk_state_e;

    localparam logic [7:0] SYNC_TRUE = 8'h47;
    localparam logic [7:0] SYNC_INV  = 8'hB8;
    localparam int         GAP_W     = 8;

    function automatic logic is_sync_byte(input logic [7:0] b);
        return (b == SYNC_TRUE) || (b == SYNC_INV);
    endfunction

    function automatic pkt_len_e len_from_gap(input logic [GAP_W-1:0] gap);
        case (gap)
            8'd188:  return LEN_188;
            8'd204:  return LEN_204;
            default: return LEN_NONE;
        endcase
    endfunction

    function automatic logic [GAP_W-1:0] len_bytes(input pkt_len_e len);
        case (len)
            LEN_188: return 8'd188;
            LEN_204: return 8'd204;
            default: return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/ts_bit_sync.sv
module ts_bit_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ts_frame_tracker.sv
module ts_frame_tracker
    import ts_mon_pkg::*;
#(
    parameter int LOCK_HITS  = 5,
    parameter int MISS_LIMIT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] byte_i,
    input  logic       valid_i,
    output logic       err_o,
    output pkt_len_e   len_o
);
    localparam int RUN_W  = $clog2(LOCK_HITS + 1);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);

    trk_state_e       state_q;
    logic [GAP_W-1:0] gap_q;
    logic [RUN_W-1:0] run_q;
    logic [MISS_W-1:0] miss_q;
    pkt_len_e         cand_q;
    pkt_len_e         len_q;

    logic             hit_sync;
    pkt_len_e         spacing;
    logic             at_slot;
    logic [GAP_W-1:0] gap_inc;

    assign hit_sync = is_sync_byte(byte_i);
    assign spacing  = len_from_gap(gap_q);
    assign at_slot  = (gap_q == len_bytes(len_q));
    assign gap_inc  = (gap_q == '1) ? gap_q : gap_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TRK_HUNT;
            gap_q   <= '0;
            run_q   <= '0;
            miss_q  <= '0;
            cand_q  <= LEN_NONE;
            len_q   <= LEN_NONE;
        end else if (valid_i) begin
            unique case (state_q)
                TRK_HUNT: begin
                    if (hit_sync) begin
                        gap_q <= GAP_W'(1);
                        if (spacing != LEN_NONE && spacing == cand_q && run_q != '0) begin
                            if (run_q == RUN_W'(LOCK_HITS - 1)) begin
                                state_q <= TRK_LOCK;
                                len_q   <= spacing;
                                run_q   <= '0;
                                miss_q  <= '0;
                                cand_q  <= LEN_NONE;
                            end else begin
                                run_q <= run_q + 1'b1;
                            end
                        end else if (spacing != LEN_NONE) begin
                            run_q  <= RUN_W'(1);
                            cand_q <= spacing;
                        end else begin
                            run_q  <= '0;
                            cand_q <= LEN_NONE;
                        end
                    end else begin
                        gap_q <= gap_inc;
                    end
                end
                TRK_LOCK: begin
                    if (at_slot) begin
                        gap_q <= GAP_W'(1);
                        if (hit_sync) begin
                            miss_q <= '0;
                        end else if (miss_q == MISS_W'(MISS_LIMIT - 1)) begin
                            state_q <= TRK_HUNT;
                            gap_q   <= '0;
                            len_q   <= LEN_NONE;
                            miss_q  <= '0;
                        end else begin
                            miss_q <= miss_q + 1'b1;
                        end
                    end else begin
                        gap_q <= gap_inc;
                    end
                end
                default: state_q <= TRK_HUNT;
            endcase
        end
    end

    assign err_o = (state_q == TRK_HUNT);
    assign len_o = len_q;

    AST_LOCK_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        $fell(err_o) |-> ($past(run_q) == RUN_W'(LOCK_HITS - 1))); // R2
    AST_LOSS_AFTER_MISSES: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> ($past(miss_q) == MISS_W'(MISS_LIMIT - 1))); // R1
    AST_LEN_ONLY_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (len_o != LEN_NONE) |-> !err_o); // R4
    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(gap_q) && $stable(state_q)); // R10

endmodule

// File: rtl/ts_clk_watch.sv
module ts_clk_watch #(
    parameter int LOSS_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tog_i,
    output logic loss_o
);
    localparam int CNT_W = $clog2(LOSS_CYCLES + 1);

    logic             tog_s;
    logic             tog_prev_q;
    logic             seen_edge;
    logic [CNT_W-1:0] cnt_q;
    logic             loss_q;

    ts_bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tog_sync (
        .clk (clk),
        .rst (rst),
        .d   (tog_i),
        .q   (tog_s)
    );

    assign seen_edge = tog_s ^ tog_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_prev_q <= 1'b0;
            cnt_q      <= '0;
            loss_q     <= 1'b0;
        end else begin
            tog_prev_q <= tog_s;
            if (seen_edge) begin
                cnt_q  <= '0;
                loss_q <= 1'b0;
            end else if (cnt_q == CNT_W'(LOSS_CYCLES - 1)) begin
                loss_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign loss_o = loss_q;

    AST_LOSS_AFTER_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(loss_q) |-> ($past(cnt_q) == CNT_W'(LOSS_CYCLES - 1))); // R7
    AST_ACTIVITY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        seen_edge |=> !loss_q); // R7

endmodule

// File: rtl/ts_status_out.sv
module ts_status_out
    import ts_mon_pkg::*;
#(
    parameter int HOLD_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     err_i,
    input  pkt_len_e len_i,
    input  logic     loss_i,
    output logic     sync_err_o,
    output logic     led_o,
    output logic     p188_o,
    output logic     p204_o,
    output logic     alarm_o,
    output logic     port_en_o
);
    localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

    logic              err_s;
    logic [1:0]        len_raw;
    pkt_len_e          len_s;
    logic [HOLD_W-1:0] hold_q;
    logic              fault;

    ts_bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_err_sync (
        .clk (clk),
        .rst (rst),
        .d   (err_i),
        .q   (err_s)
    );

    ts_bit_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_len_sync (
        .clk (clk),
        .rst (rst),
        .d   (logic'(len_i[1]) ? 2'b10 : {1'b0, len_i[0]}),
        .q   (len_raw)
    );

    assign len_s = pkt_len_e'(len_raw);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (err_s) begin
            hold_q <= HOLD_W'(HOLD_CYCLES);
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    assign fault      = err_s || loss_i;
    assign sync_err_o = err_s;
    assign led_o      = err_s || (hold_q != '0);
    assign p188_o     = !fault && (len_s == LEN_188);
    assign p204_o     = !fault && (len_s == LEN_204);
    assign alarm_o    = fault;
    assign port_en_o  = !loss_i;

    AST_LED_DURING_ERR: assert property (@(posedge clk) disable iff (rst)
        err_s |-> led_o); // R6
    AST_HOLD_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!err_s && hold_q != '0) |=> (err_s || hold_q == $past(hold_q) - 1'b1)); // R6
    AST_HOLD_LOADED_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(err_s) |-> (hold_q == HOLD_W'(HOLD_CYCLES))); // R6

endmodule

// File: rtl/ts_sync_monitor.sv
module ts_sync_monitor
    import ts_mon_pkg::*;
#(
    parameter int LOCK_HITS   = 5,
    parameter int MISS_LIMIT  = 2,
    parameter int HOLD_CYCLES = 8_100_000,
    parameter int LOSS_CYCLES = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_ref,
    input  logic       clk_ts,
    input  logic       rst,
    input  logic [7:0] ts_byte,
    input  logic       ts_valid,
    output logic       sync_err,
    output logic       err_led,
    output logic       pkt188,
    output logic       pkt204,
    output logic       input_loss,
    output logic       alarm,
    output logic       port_en
);
    logic     trk_err;
    pkt_len_e trk_len;
    logic     tog_q;
    logic     loss;

    always_ff @(posedge clk_ts) begin
        if (rst) tog_q <= 1'b0;
        else     tog_q <= ~tog_q;
    end

    ts_frame_tracker #(.LOCK_HITS(LOCK_HITS), .MISS_LIMIT(MISS_LIMIT)) u_tracker (
        .clk     (clk_ts),
        .rst     (rst),
        .byte_i  (ts_byte),
        .valid_i (ts_valid),
        .err_o   (trk_err),
        .len_o   (trk_len)
    );

    ts_clk_watch #(.LOSS_CYCLES(LOSS_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_watch (
        .clk    (clk_ref),
        .rst    (rst),
        .tog_i  (tog_q),
        .loss_o (loss)
    );

    ts_status_out #(.HOLD_CYCLES(HOLD_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_status (
        .clk        (clk_ref),
        .rst        (rst),
        .err_i      (trk_err),
        .len_i      (trk_len),
        .loss_i     (loss),
        .sync_err_o (sync_err),
        .led_o      (err_led),
        .p188_o     (pkt188),
        .p204_o     (pkt204),
        .alarm_o    (alarm),
        .port_en_o  (port_en)
    );

    assign input_loss = loss;

    AST_ONE_LENGTH: assert property (@(posedge clk_ref) disable iff (rst)
        $onehot0({pkt188, pkt204})); // R4
    AST_BLANK_IN_FAULT: assert property (@(posedge clk_ref) disable iff (rst)
        (pkt188 || pkt204) |-> (!alarm && port_en)); // R8
    AST_PORT_FOLLOWS_LOSS: assert property (@(posedge clk_ref) disable iff (rst)
        input_loss |-> (alarm && !port_en)); // R7

endmodule

// File: tb/ts_sync_monitor_test.sv
module ts_sync_monitor_test;
    localparam int REF_PERIOD = 10;
    localparam int TS_HALF    = 7;
    localparam int HOLD       = 40;
    localparam int LOSS       = 16;

    logic       clk_ref  = 1'b0;
    logic       clk_ts   = 1'b0;
    logic       ts_run   = 1'b1;
    logic       rst      = 1'b1;
    logic [7:0] ts_byte  = 8'h00;
    logic       ts_valid = 1'b0;

    logic sync_err, err_led, pkt188, pkt204, input_loss, alarm, port_en;

    int total = 0;
    int bad   = 0;
    int hold_meas = -1;
    int hold_cnt  = 0;
    logic hold_armed = 1'b0;

    ts_sync_monitor #(
        .LOCK_HITS(5), .MISS_LIMIT(2), .HOLD_CYCLES(HOLD),
        .LOSS_CYCLES(LOSS), .SYNC_STAGES(2)
    ) uut (
        .clk_ref(clk_ref), .clk_ts(clk_ts), .rst(rst),
        .ts_byte(ts_byte), .ts_valid(ts_valid),
        .sync_err(sync_err), .err_led(err_led), .pkt188(pkt188), .pkt204(pkt204),
        .input_loss(input_loss), .alarm(alarm), .port_en(port_en)
    );

    always #(REF_PERIOD/2) clk_ref = ~clk_ref;
    always begin
        #(TS_HALF);
        if (ts_run) clk_ts = ~clk_ts;
    end

    // Lamp hold measurement: samples high while sync_err reads low (R6)
    always @(negedge clk_ref) begin
        if (rst || sync_err === 1'b1) begin
            hold_cnt   <= 0;
            hold_armed <= 1'b1;
        end else if (hold_armed) begin
            if (err_led === 1'b1) hold_cnt <= hold_cnt + 1;
            else begin
                hold_meas  <= hold_cnt;
                hold_armed <= 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic v);
        @(negedge clk_ts);
        ts_byte  = b;
        ts_valid = v;
    endtask

    task automatic send_pkt(input int len, input logic [7:0] sval, input int seed,
                            input bit gaps, input int inject_at);
        push(sval, 1'b1);
        for (int i = 1; i < len; i++) begin
            if (gaps && (i % 16 == 5)) push(8'h47, 1'b0);
            if (i == inject_at) push(8'h47, 1'b1);
            else if (i == inject_at + 1) push(8'hB8, 1'b1);
            else push(8'((i * 5 + seed) % 64), 1'b1);
        end
        push(8'h00, 1'b0);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk_ref);
    endtask

    initial begin
        #(REF_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (10) @(posedge clk_ref);
        @(negedge clk_ref);
        rst = 1'b0;
        settle();

        chk("R9 sync_err after reset", sync_err, 1);
        chk("R9 err_led after reset", err_led, 1);
        chk("R9 alarm after reset", alarm, 1);
        chk("R9 pkt188 after reset", pkt188, 0);
        chk("R9 pkt204 after reset", pkt204, 0);
        chk("R9 input_loss after reset", input_loss, 0);
        chk("R9 port_en after reset", port_en, 1);

        // R2 R3 R10: mixed 0x47/0xB8 headers, invalid 0x47 cycles interleaved
        for (int p = 0; p < 5; p++)
            send_pkt(188, (p % 2) ? 8'hB8 : 8'h47, p, 1'b1, -10);
        settle();
        chk("R2 no lock after five sync bytes", sync_err, 1);
        send_pkt(188, 8'hB8, 9, 1'b1, -10);
        settle();
        chk("R2 lock on sixth sync byte", sync_err, 0);
        chk("R3 inverted sync accepted", pkt188, 1);
        chk("R10 invalid cycles ignored", pkt204, 0);
        chk("R8 alarm clear when locked", alarm, 0);
        chk("R6 lamp hold length", hold_meas, HOLD);
        chk("R6 lamp off after hold", err_led, 0);

        // R5: stray sync values inside payload while locked
        send_pkt(188, 8'h47, 3, 1'b0, 100);
        send_pkt(188, 8'h47, 4, 1'b0, 37);
        settle();
        chk("R5 payload sync bytes ignored", sync_err, 0);
        chk("R5 length kept", pkt188, 1);

        // R1: miss, good, miss keeps lock; miss, miss drops it
        send_pkt(188, 8'h00, 1, 1'b0, -10);
        settle();
        chk("R1 single miss keeps lock", sync_err, 0);
        send_pkt(188, 8'h47, 2, 1'b0, -10);
        send_pkt(188, 8'h12, 3, 1'b0, -10);
        settle();
        chk("R1 miss tally reset by good sync", sync_err, 0);
        send_pkt(188, 8'h00, 4, 1'b0, -10);
        settle();
        chk("R1 two consecutive misses", sync_err, 1);
        chk("R8 alarm on sync error", alarm, 1);
        chk("R8 pkt188 blanked", pkt188, 0);
        chk("R6 lamp lit during error", err_led, 1);

        // R3: look-alike header never locks
        for (int p = 0; p < 7; p++) send_pkt(188, 8'h48, p, 1'b0, -10);
        settle();
        chk("R3 0x48 not a sync byte", sync_err, 1);

        // R4: alternating spacings never lock
        for (int p = 0; p < 8; p++) send_pkt((p % 2) ? 204 : 188, 8'h47, p, 1'b0, -10);
        settle();
        chk("R4 alternating spacing no lock", sync_err, 1);
        chk("R4 no length shown", pkt188 | pkt204, 0);

        // R2: a wrong spacing restarts the run
        for (int p = 0; p < 4; p++) send_pkt(188, 8'h47, p, 1'b0, -10);
        send_pkt(150, 8'h47, 7, 1'b0, -10);
        for (int p = 0; p < 5; p++) send_pkt(188, 8'h47, p, 1'b0, -10);
        settle();
        chk("R2 run restarted by bad spacing", sync_err, 1);
        send_pkt(188, 8'h47, 8, 1'b0, -10);
        settle();
        chk("R2 lock after restarted run", sync_err, 0);

        // R4: re-lock to 204-byte packets
        send_pkt(188, 8'h00, 1, 1'b0, -10);
        send_pkt(188, 8'h00, 2, 1'b0, -10);
        for (int p = 0; p < 5; p++) send_pkt(204, 8'h47, p, 1'b0, -10);
        settle();
        chk("R4 no 204 lock after five", sync_err, 1);
        send_pkt(204, 8'hB8, 5, 1'b0, -10);
        settle();
        chk("R4 locked to 204", pkt204, 1);
        chk("R4 188 off when 204", pkt188, 0);

        // R7 R8: stream clock stops and restarts
        ts_run = 1'b0;
        repeat (8) @(negedge clk_ref);
        chk("R7 no early loss", input_loss, 0);
        repeat (32) @(negedge clk_ref);
        chk("R7 loss on stopped clock", input_loss, 1);
        chk("R7 port disabled", port_en, 0);
        chk("R8 alarm on loss", alarm, 1);
        chk("R8 pkt204 blanked on loss", pkt204, 0);
        ts_run = 1'b1;
        repeat (12) @(negedge clk_ref);
        chk("R7 loss clears", input_loss, 0);
        chk("R7 port re-enabled", port_en, 1);
        chk("R8 indicator back", pkt204, 1);
        chk("R8 alarm clear", alarm, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule